// File: doc/BRIEF.md
# Two-Core Utility Way Partitioner

This block decides how the ways of a shared set-associative cache are divided between two cores. Each core has a utility monitor that counts, per recency position, how many hits its accesses would have seen (position 0 is the most recently used). When an interval timer pulses `start_i`, the block takes a copy of both counter vectors. It then tries every legal split in turn. If core 1 gets `a` ways, core 2 gets `NUM_WAYS - a` ways. The score of a split is the sum of core 1's first `a` counters and core 2's first `NUM_WAYS - a` counters. The block keeps the split with the highest score.

The search is sequential. It first makes a preload pass that totals core 2's counters. It then makes a scan pass that looks at one candidate per cycle. Each step adds one of core 1's counters to its running sum and takes one of core 2's counters off its running sum. At the end the winning allocation is latched, and a one-cycle `done_o` pulse marks it. The caller pulses `start_i` once per repartitioning interval; the intended interval is about five million cycles. The allocation stays in force until the next run completes. Enforcing the split in the cache's replacement logic is left to other blocks.

Top module: `way_partitioner`

## Requirements
- R1: During and straight after reset, `done_o` is 0 and each core is allocated `NUM_WAYS/2` ways.
- R2: Counter `p` of a core sits at bits `[p*CNT_W +: CNT_W]` of its input vector, with `p = 0` the MRU position. At the end of a run, `core1_ways_o = a` and `core2_ways_o = NUM_WAYS - a`. Here `a` maximises `sum(c1[0..a-1]) + sum(c2[0..NUM_WAYS-a-1])` over all candidates.
- R3: Only candidates `a` from 1 to `NUM_WAYS-1` are considered, so each core always keeps at least one way.
- R4: When several candidates reach the same best total, the smallest `a` is chosen.
- R5: `done_o` rises exactly `2*NUM_WAYS-2` clock edges after the edge that samples `start_i` high while idle. It stays high for exactly one cycle.
- R6: The counter inputs are sampled only at the edge that accepts `start_i`. Changing them later during the run does not affect the result.
- R7: A `start_i` pulse that arrives while a run is in progress is ignored. It neither restarts the run nor causes a second `done_o`.
- R8: `core1_ways_o` and `core2_ways_o` change only on the edge that raises `done_o`. Between completions they hold, whatever the counter inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Interval pulse that requests a new partition |
| c1_hits_i | input | NUM_WAYS*CNT_W | Core 1 per-position hit counters |
| c2_hits_i | input | NUM_WAYS*CNT_W | Core 2 per-position hit counters |
| core1_ways_o | output | $clog2(NUM_WAYS+1) | Ways granted to core 1 |
| core2_ways_o | output | $clog2(NUM_WAYS+1) | Ways granted to core 2 |
| done_o | output | 1 | One-cycle pulse when a new allocation is latched |

## Verification
The bench builds the block with `NUM_WAYS = 8` and `CNT_W = 8`. With these values a run takes 14 cycles, so many runs fit in a short test: dominant-core cases that land on both edge candidates, crafted ties, and pseudo-random counter sets. Eight-bit counters let the bench drive every counter to its maximum and still stay inside the score width. The preload and scan passes each have few enough steps that an error at either end of either pass shows up in the chosen split or in the latency.

// File: rtl/wp_pkg.sv
// Shared types for the way partitioner.
package wp_pkg;
    typedef enum logic [1:0] {
        WP_IDLE    = 2'd0,
        WP_PRELOAD = 2'd1,
        WP_SCAN    = 2'd2
    } wp_state_e;
endpackage

// File: rtl/wp_hit_store.sv
// Snapshot of both cores' hit counters, taken when a run is accepted.
// Assumes position p of a vector sits at bits [p*CNT_W +: CNT_W].
// Gives two independent read ports, one for each core.
module wp_hit_store #(
    parameter int NUM_WAYS = 16,
    parameter int CNT_W    = 16,
    parameter int IDX_W    = $clog2(NUM_WAYS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      capture_i,
    input  logic [NUM_WAYS*CNT_W-1:0] c1_hits_i,
    input  logic [NUM_WAYS*CNT_W-1:0] c2_hits_i,
    input  logic [IDX_W-1:0]          rd1_idx_i,
    input  logic [IDX_W-1:0]          rd2_idx_i,
    output logic [CNT_W-1:0]          rd1_o,
    output logic [CNT_W-1:0]          rd2_o
);
    logic [CNT_W-1:0] snap1 [NUM_WAYS];
    logic [CNT_W-1:0] snap2 [NUM_WAYS];

    for (genvar p = 0; p < NUM_WAYS; p++) begin : g_pos
        // Copy one recency position of each core when a capture happens.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                snap1[p] <= '0;
                snap2[p] <= '0;
            end else if (capture_i) begin
                snap1[p] <= c1_hits_i[p*CNT_W +: CNT_W];
                snap2[p] <= c2_hits_i[p*CNT_W +: CNT_W];
            end
        end
    end

    // Read muxes for the two score accumulators.
    always_comb begin
        rd1_o = snap1[rd1_idx_i];
        rd2_o = snap2[rd2_idx_i];
    end
endmodule

// File: rtl/wp_ctrl.sv
// Sequencer: idle -> preload (core 2 total of positions 0..W-2) -> scan
// (candidates 1..W-1, one per cycle) -> idle. Starts are only taken when idle.
module wp_ctrl
    import wp_pkg::*;
#(
    parameter int NUM_WAYS = 16,
    parameter int IDX_W    = $clog2(NUM_WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output wp_state_e        state_o,
    output logic [IDX_W-1:0] step_o,
    output logic             capture_o
);
    localparam logic [IDX_W-1:0] LAST_PRE  = IDX_W'(NUM_WAYS - 2);
    localparam logic [IDX_W-1:0] LAST_CAND = IDX_W'(NUM_WAYS - 1);

    wp_state_e        state;
    logic [IDX_W-1:0] step;

    // A start is accepted only while no run is active.
    always_comb capture_o = (state == WP_IDLE) && start_i;

    // State and step counter for both passes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= WP_IDLE;
            step  <= '0;
        end else begin
            case (state)
                WP_IDLE: begin
                    if (start_i) begin
                        state <= WP_PRELOAD;
                        step  <= '0;
                    end
                end
                WP_PRELOAD: begin
                    if (step == LAST_PRE) begin
                        state <= WP_SCAN;
                        step  <= IDX_W'(1);
                    end else begin
                        step <= step + 1'b1;
                    end
                end
                WP_SCAN: begin
                    if (step == LAST_CAND) begin
                        state <= WP_IDLE;
                        step  <= '0;
                    end else begin
                        step <= step + 1'b1;
                    end
                end
                default: begin
                    state <= WP_IDLE;
                    step  <= '0;
                end
            endcase
        end
    end

    always_comb begin
        state_o = state;
        step_o  = step;
    end
endmodule

// File: rtl/wp_score_acc.sv
// Running prefix sums. Core 2's sum is built up during preload and trimmed
// during scan. Core 1's sum starts at position 0 and grows during scan.
// After scan step a, the sums hold the scores for candidate a.
module wp_score_acc
    import wp_pkg::*;
#(
    parameter int NUM_WAYS = 16,
    parameter int CNT_W    = 16,
    parameter int IDX_W    = $clog2(NUM_WAYS),
    parameter int SUM_W    = CNT_W + $clog2(NUM_WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  wp_state_e        state_i,
    input  logic [IDX_W-1:0] step_i,
    input  logic [CNT_W-1:0] rd1_i,
    input  logic [CNT_W-1:0] rd2_i,
    output logic [SUM_W-1:0] sum1_o,
    output logic [SUM_W-1:0] sum2_o
);
    logic [SUM_W-1:0] sum1, sum2;

    // Update both sums according to the current pass.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            sum1 <= '0;
            sum2 <= '0;
        end else if (state_i == WP_PRELOAD) begin
            sum2 <= sum2 + SUM_W'(rd2_i);
            if (step_i == '0) sum1 <= SUM_W'(rd1_i);
        end else if (state_i == WP_SCAN) begin
            sum1 <= sum1 + SUM_W'(rd1_i);
            sum2 <= sum2 - SUM_W'(rd2_i);
        end
    end

    always_comb begin
        sum1_o = sum1;
        sum2_o = sum2;
    end
endmodule

// File: rtl/wp_best_track.sv
// Keeps the best candidate seen so far, using a strict compare so the
// earliest (smallest) candidate wins a tie. It latches the result and pulses
// done after the last candidate. Assumes the candidates arrive in increasing order.
module wp_best_track #(
    parameter int NUM_WAYS = 16,
    parameter int IDX_W    = $clog2(NUM_WAYS),
    parameter int TOT_W    = 20,
    parameter int AW       = $clog2(NUM_WAYS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eval_i,
    input  logic             first_i,
    input  logic             last_i,
    input  logic [IDX_W-1:0] cand_i,
    input  logic [TOT_W-1:0] total_i,
    output logic [AW-1:0]    core1_ways_o,
    output logic [AW-1:0]    core2_ways_o,
    output logic             done_o
);
    logic [TOT_W-1:0] best_total;
    logic [IDX_W-1:0] best_cand;
    logic             take;
    logic [IDX_W-1:0] pick;

    // The current candidate replaces the best if it is first or strictly better.
    always_comb begin
        take = first_i || (total_i > best_total);
        pick = take ? cand_i : best_cand;
    end

    // Best-so-far registers, the held allocation and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            best_total   <= '0;
            best_cand    <= IDX_W'(1);
            core1_ways_o <= AW'(NUM_WAYS / 2);
            core2_ways_o <= AW'(NUM_WAYS - NUM_WAYS / 2);
            done_o       <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (eval_i) begin
                if (take) begin
                    best_total <= total_i;
                    best_cand  <= cand_i;
                end
                if (last_i) begin
                    core1_ways_o <= AW'(pick);
                    core2_ways_o <= AW'(NUM_WAYS) - AW'(pick);
                    done_o       <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/way_partitioner.sv
// Top: exhaustive search over the two-core way splits of a shared cache.
// Assumes NUM_WAYS >= 2 and that start_i comes from an external interval timer.
module way_partitioner
    import wp_pkg::*;
#(
    parameter int NUM_WAYS = 16,
    parameter int CNT_W    = 16,
    parameter int AW       = $clog2(NUM_WAYS + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic [NUM_WAYS*CNT_W-1:0] c1_hits_i,
    input  logic [NUM_WAYS*CNT_W-1:0] c2_hits_i,
    output logic [AW-1:0]             core1_ways_o,
    output logic [AW-1:0]             core2_ways_o,
    output logic                      done_o
);
    localparam int IDX_W = $clog2(NUM_WAYS);
    localparam int SUM_W = CNT_W + $clog2(NUM_WAYS);
    localparam int TOT_W = SUM_W + 1;
    localparam logic [IDX_W-1:0] LAST_CAND = IDX_W'(NUM_WAYS - 1);

    wp_state_e        state;
    logic [IDX_W-1:0] step;
    logic             capture;
    logic [IDX_W-1:0] rd1_idx, rd2_idx;
    logic [CNT_W-1:0] rd1, rd2;
    logic [SUM_W-1:0] sum1, sum2;
    logic [TOT_W-1:0] total;

    wp_ctrl #(.NUM_WAYS(NUM_WAYS), .IDX_W(IDX_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .state_o(state), .step_o(step), .capture_o(capture)
    );

    // Core 1 reads position step. Core 2 reads forward in preload and backward in scan.
    always_comb begin
        rd1_idx = step;
        rd2_idx = (state == WP_SCAN) ? (LAST_CAND - step) : step;
    end

    wp_hit_store #(.NUM_WAYS(NUM_WAYS), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst_n(rst_n), .capture_i(capture),
        .c1_hits_i(c1_hits_i), .c2_hits_i(c2_hits_i),
        .rd1_idx_i(rd1_idx), .rd2_idx_i(rd2_idx),
        .rd1_o(rd1), .rd2_o(rd2)
    );

    wp_score_acc #(.NUM_WAYS(NUM_WAYS), .CNT_W(CNT_W), .IDX_W(IDX_W), .SUM_W(SUM_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .clear_i(capture), .state_i(state), .step_i(step),
        .rd1_i(rd1), .rd2_i(rd2), .sum1_o(sum1), .sum2_o(sum2)
    );

    // Score of the candidate now under evaluation.
    always_comb total = TOT_W'(sum1) + TOT_W'(sum2);

    wp_best_track #(.NUM_WAYS(NUM_WAYS), .IDX_W(IDX_W), .TOT_W(TOT_W), .AW(AW)) u_best (
        .clk(clk), .rst_n(rst_n),
        .eval_i(state == WP_SCAN),
        .first_i(step == IDX_W'(1)),
        .last_i(step == LAST_CAND),
        .cand_i(step), .total_i(total),
        .core1_ways_o(core1_ways_o), .core2_ways_o(core2_ways_o), .done_o(done_o)
    );
endmodule

// File: rtl/wp_checker.sv
// Port-level checker for way_partitioner. It tracks runs with its own
// counter and does not look at the design's internal state.
module wp_checker #(
    parameter int NUM_WAYS = 16,
    parameter int AW       = $clog2(NUM_WAYS + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          done_o,
    input logic [AW-1:0] core1_ways_o,
    input logic [AW-1:0] core2_ways_o
);
    localparam int LAT   = 2 * NUM_WAYS - 2;
    localparam int CNT_W = $clog2(2 * NUM_WAYS + 2) + 1;

    logic             chk_busy;
    logic [CNT_W-1:0] chk_cnt;

    // Shadow of the run window, started by an accepted start_i.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_busy <= 1'b0;
            chk_cnt  <= '0;
        end else begin
            if (chk_busy && done_o) chk_busy <= 1'b0;
            if (start_i && (!chk_busy || done_o)) begin
                chk_busy <= 1'b1;
                chk_cnt  <= '0;
            end else if (chk_busy && !done_o && chk_cnt != '1) begin
                chk_cnt <= chk_cnt + 1'b1;
            end
        end
    end

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R5
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (chk_busy && chk_cnt == CNT_W'(LAT)));

    // R7
    no_stray_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_busy |-> !done_o);

    // R3
    ways_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core1_ways_o >= AW'(1)) && (core1_ways_o <= AW'(NUM_WAYS - 1)));

    // R8
    alloc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(core1_ways_o) && $stable(core2_ways_o)));
endmodule

bind way_partitioner wp_checker #(.NUM_WAYS(NUM_WAYS), .AW(AW)) u_wp_checker (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .done_o(done_o),
    .core1_ways_o(core1_ways_o), .core2_ways_o(core2_ways_o)
);

// File: tb/way_partitioner_bench.sv
// Directed bench for way_partitioner: one task per scenario.
module way_partitioner_bench;
    localparam int W   = 8;
    localparam int C   = 8;
    localparam int AW  = $clog2(W + 1);
    localparam int LAT = 2 * W - 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [W*C-1:0]   v1 = '0, v2 = '0;
    logic [AW-1:0]    w1, w2;
    logic             done;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    int run_cycles;
    bit saw_done;
    logic [31:0] seed = 32'h1234_5678;

    way_partitioner #(.NUM_WAYS(W), .CNT_W(C)) u_way_partitioner (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .c1_hits_i(v1), .c2_hits_i(v2),
        .core1_ways_o(w1), .core2_ways_o(w2), .done_o(done)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference: best split per the requirements (strict compare, smallest a wins).
    function automatic int ref_best(input logic [W*C-1:0] a1, input logic [W*C-1:0] a2);
        int best = 1;
        int best_tot = -1;
        for (int a = 1; a < W; a++) begin
            int tot = 0;
            for (int p = 0; p < a; p++) tot += int'(a1[p*C +: C]);
            for (int p = 0; p < W - a; p++) tot += int'(a2[p*C +: C]);
            if (tot > best_tot) begin
                best_tot = tot;
                best = a;
            end
        end
        return best;
    endfunction

    function automatic logic [W*C-1:0] fill(input int val);
        logic [W*C-1:0] r;
        for (int p = 0; p < W; p++) r[p*C +: C] = C'(val);
        return r;
    endfunction

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        logic [31:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    // Pulse start, optionally disturb inputs or re-pulse start, and wait for done.
    task automatic launch(input bit disturb, input bit restart);
        @(negedge clk); start = 1'b1;
        @(posedge clk);
        @(negedge clk); start = 1'b0;
        if (disturb) begin
            v1 = ~v1;
            v2 = fill(C'(255));
        end
        run_cycles = 0;
        saw_done = 0;
        while (!saw_done && run_cycles < 200) begin
            @(posedge clk);
            run_cycles++;
            @(negedge clk);
            if (restart && run_cycles == 3) start = 1'b1;
            if (restart && run_cycles == 4) start = 1'b0;
            if (done) saw_done = 1;
        end
    endtask

    // Run one partition and check allocation, latency and pulse width.
    task automatic run_check(input string req, input int exp_a);
        launch(0, 0);
        check(saw_done && run_cycles == LAT, "R5 latency", run_cycles, LAT);
        check(int'(w1) == exp_a, {req, " core1 ways"}, int'(w1), exp_a);
        check(int'(w2) == W - exp_a, {req, " core2 ways"}, int'(w2), W - exp_a);
        @(negedge clk);
        check(done == 1'b0, "R5 single-cycle done", int'(done), 0);
    endtask

    task automatic t_reset();
        check(done == 1'b0, "R1 done at reset", int'(done), 0);
        check(int'(w1) == W / 2, "R1 core1 at reset", int'(w1), W / 2);
        check(int'(w2) == W / 2, "R1 core2 at reset", int'(w2), W / 2);
    endtask

    task automatic t_core1_heavy();
        v1 = fill(200); v2 = fill(1);
        run_check("R3 upper edge", W - 1);
    endtask

    task automatic t_core2_heavy();
        v1 = fill(1); v2 = fill(200);
        run_check("R3 lower edge", 1);
    endtask

    task automatic t_zero_tie();
        v1 = '0; v2 = '0;
        run_check("R4 all-zero tie", 1);
    endtask

    task automatic t_inner_tie();
        // R4: candidates 3..7 all score 18, so 3 must win.
        v1 = '0; v2 = '0;
        v1[2*C +: C] = 8'd9;
        v2[0 +: C] = 8'd9;
        run_check("R4 inner tie", 3);
    endtask

    task automatic t_max_counts();
        v1 = fill(255); v2 = fill(255);
        run_check("R2 saturated counters", 1);
    endtask

    task automatic t_random(input int runs);
        for (int r = 0; r < runs; r++) begin
            for (int p = 0; p < W; p++) begin
                seed = next_rand(seed); v1[p*C +: C] = seed[C-1:0];
                seed = next_rand(seed); v2[p*C +: C] = seed[C-1:0];
            end
            run_check("R2 random", ref_best(v1, v2));
        end
    endtask

    task automatic t_snapshot();
        int exp_a;
        v1 = fill(1); v2 = '0;
        v1[0 +: C] = 8'd1;
        v2[0 +: C] = 8'd50;
        exp_a = ref_best(v1, v2);
        launch(1, 0);
        check(int'(w1) == exp_a, "R6 snapshot core1", int'(w1), exp_a);
        check(int'(w2) == W - exp_a, "R6 snapshot core2", int'(w2), W - exp_a);
    endtask

    task automatic t_restart_ignored();
        bit extra = 0;
        v1 = fill(3); v2 = fill(1);
        launch(0, 1);
        check(saw_done && run_cycles == LAT, "R7 latency with mid-run start", run_cycles, LAT);
        for (int i = 0; i < 2 * W + 2; i++) begin
            @(negedge clk);
            if (done) extra = 1;
        end
        check(extra == 0, "R7 no second done", int'(extra), 0);
    endtask

    task automatic t_hold();
        logic [AW-1:0] h1, h2;
        bit moved = 0;
        h1 = w1; h2 = w2;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            v1 = fill(i * 7); v2 = fill(255 - i * 5);
            if (w1 != h1 || w2 != h2 || done) moved = 1;
        end
        check(moved == 0, "R8 allocation held", int'(moved), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_core1_heavy();
        t_hold();
        t_core2_heavy();
        t_zero_tie();
        t_inner_tie();
        t_max_counts();
        t_random(12);
        t_snapshot();
        t_restart_ignored();
        t_hold();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule